// File: doc/BRIEF.md
# Per-Processor Boot Run-Control Sequencer

One copy of this controller sits beside each processor of a symmetric multiprocessor. It takes its processor out of power-on reset without waiting for any other processor. It holds the processor in reset for a programmable initialization interval, then releases it to fetch from a fixed boot ROM entry address. While firmware runs, one processor is elected master through a shared election mechanism outside this block. The result of that election is delivered to every copy of the sequencer. The master keeps running. Every other processor is parked in a stopped state, where the core is held and the remembered start address is wiped.

A parked processor leaves the stopped state in only one way: an inter-processor wake request. That request must name this processor's wired identity and carry a fresh entry address. The processor is then released at that address as a secondary. A matching wake request that arrives while the sequencer is in any other state changes nothing except a sticky error flag. A request aimed at a different identity is simply not addressed to this copy. Unlike an idle state, the stopped state keeps no context, which is why every wake has to supply its own address.

Top module: `boot_runctl`

## Requirements
- R1: While `rst_ni` is low, `state_o` is 0, `core_rst_o` and `core_hold_o` are 1, `fetch_addr_o` is 0 and `wake_err_o` is 0. The state codes on `state_o` are: 0 reset, 1 init, 2 boot release, 3 election wait, 4 master run, 5 stopped, 6 secondary run.
- R2: One clock after reset is released the state is 1. It stays at 1 for max(`init_len_i`,1) clocks and then becomes 2. `core_rst_o` and `core_hold_o` are 1 throughout states 0 and 1.
- R3: In state 2, `fetch_addr_o` equals `ROM_ENTRY`, and `core_rst_o` and `core_hold_o` are 0. State 2 lasts exactly one clock and is followed by state 3.
- R4: State 3 persists until `elect_valid_i` is sampled high. On the next clock the state becomes 4 if `elect_master_i` is 1, or 5 if it is 0. `elect_valid_i` has no effect in any other state.
- R5: In state 5, `core_hold_o` is 1, `core_rst_o` is 0 and `fetch_addr_o` is 0, so no boot address is kept.
- R6: In state 5, a wake request (`wake_valid_i` high and `wake_target_i` equal to `self_id_i`) makes the state 6 on the next clock. `fetch_addr_o` then equals the request's `wake_addr_i` and `core_hold_o` is 0.
- R7: A wake request whose target differs from `self_id_i` has no effect in any state. In particular it does not set `wake_err_o`.
- R8: A wake request whose target matches, arriving in any state other than 5, leaves the state and `fetch_addr_o` unchanged. It sets `wake_err_o` on the next clock, and the flag stays set until reset.
- R9: States 4 and 6 persist until reset. In state 4 `fetch_addr_o` stays `ROM_ENTRY`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| self_id_i | input | ID_W | Hardwired processor identity |
| init_len_i | input | CNT_W | Initialization interval in clocks (0 treated as 1) |
| elect_valid_i | input | 1 | Election result is valid this clock |
| elect_master_i | input | 1 | 1 when this processor won the election |
| wake_valid_i | input | 1 | Inter-processor wake request valid |
| wake_target_i | input | ID_W | Identity the wake request is aimed at |
| wake_addr_i | input | ADDR_W | Entry address carried by the wake request |
| core_rst_o | output | 1 | Processor reset |
| core_hold_o | output | 1 | Processor hold (no fetch, no bus activity) |
| fetch_addr_o | output | ADDR_W | Fetch start address for the processor |
| state_o | output | 3 | Current sequencer state code |
| wake_err_o | output | 1 | Sticky misplaced-wake flag |

## Verification
Every result of this block is registered once. An election or wake input sampled at one edge shows up on the outputs after that edge and not before. The state moves from reset to init one clock after release, and reaches boot release max(`init_len_i`,1)+1 clocks after release. The bench changes inputs on the falling edge and samples all outputs on the next falling edge, so each check observes exactly the register update from the edge in between. For the init interval, the bench counts falling edges from reset release up to the first boot release code and compares that count with the computed value.

// File: rtl/boot_runctl_pkg.sv
package boot_runctl_pkg;

    localparam int unsigned STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_RESET         = 3'd0,
        ST_INIT          = 3'd1,
        ST_RUN_BOOT      = 3'd2,
        ST_ELECT_WAIT    = 3'd3,
        ST_MASTER_RUN    = 3'd4,
        ST_STOPPED       = 3'd5,
        ST_RUN_SECONDARY = 3'd6
    } boot_state_e;

endpackage

// File: rtl/boot_init_timer.sv
// Counts clocks spent in the init state; clears whenever not running.
module boot_init_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   next_w;

    always_comb begin
        next_w = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
        done_o = run_i && (next_w >= {1'b0, len_i});
        cnt_d  = (run_i && !done_o) ? next_w[CNT_W-1:0] : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/boot_wake_filter.sv
// Decodes wake requests aimed at this processor and splits them into
// accepted (processor parked) and misplaced (any other state).
module boot_wake_filter #(
    parameter int unsigned ID_W = 2
) (
    input  logic            wake_valid_i,
    input  logic [ID_W-1:0] wake_target_i,
    input  logic [ID_W-1:0] self_id_i,
    input  logic            parked_i,
    output logic            accept_o,
    output logic            stray_o
);

    logic hit_w;

    always_comb begin
        hit_w    = wake_valid_i && (wake_target_i == self_id_i);
        accept_o = hit_w && parked_i;
        stray_o  = hit_w && !parked_i;
    end

endmodule

// File: rtl/boot_runctl.sv
module boot_runctl
    import boot_runctl_pkg::*;
#(
    parameter int unsigned ID_W      = 2,
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned CNT_W     = 8,
    parameter logic [ADDR_W-1:0] ROM_ENTRY = 32'hFFF0_0100
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ID_W-1:0]   self_id_i,
    input  logic [CNT_W-1:0]  init_len_i,
    input  logic              elect_valid_i,
    input  logic              elect_master_i,
    input  logic              wake_valid_i,
    input  logic [ID_W-1:0]   wake_target_i,
    input  logic [ADDR_W-1:0] wake_addr_i,
    output logic              core_rst_o,
    output logic              core_hold_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    output logic [STATE_W-1:0] state_o,
    output logic              wake_err_o
);

    typedef struct packed {
        boot_state_e       state;
        logic [ADDR_W-1:0] fetch;
        logic              err;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;
    logic      init_done_w;
    logic      wake_accept_w;
    logic      wake_stray_w;

    boot_init_timer #(
        .CNT_W (CNT_W)
    ) i_init_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (cur_q.state == ST_INIT),
        .len_i  (init_len_i),
        .done_o (init_done_w)
    );

    boot_wake_filter #(
        .ID_W (ID_W)
    ) i_wake_filter (
        .wake_valid_i  (wake_valid_i),
        .wake_target_i (wake_target_i),
        .self_id_i     (self_id_i),
        .parked_i      (cur_q.state == ST_STOPPED),
        .accept_o      (wake_accept_w),
        .stray_o       (wake_stray_w)
    );

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.state)
            ST_RESET: begin
                nxt_d.state = ST_INIT;
                nxt_d.fetch = '0;
            end
            ST_INIT: begin
                if (init_done_w) begin
                    nxt_d.state = ST_RUN_BOOT;
                    nxt_d.fetch = ROM_ENTRY;
                end
            end
            ST_RUN_BOOT: begin
                nxt_d.state = ST_ELECT_WAIT;
            end
            ST_ELECT_WAIT: begin
                if (elect_valid_i) begin
                    if (elect_master_i) begin
                        nxt_d.state = ST_MASTER_RUN;
                    end else begin
                        nxt_d.state = ST_STOPPED;
                        nxt_d.fetch = '0;
                    end
                end
            end
            ST_STOPPED: begin
                nxt_d.fetch = '0;
                if (wake_accept_w) begin
                    nxt_d.state = ST_RUN_SECONDARY;
                    nxt_d.fetch = wake_addr_i;
                end
            end
            ST_MASTER_RUN, ST_RUN_SECONDARY: begin
                nxt_d.state = cur_q.state;
            end
            default: begin
                nxt_d.state = ST_RESET;
                nxt_d.fetch = '0;
            end
        endcase
        if (wake_stray_w) begin
            nxt_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '{state: ST_RESET, fetch: '0, err: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        core_rst_o   = (cur_q.state == ST_RESET) || (cur_q.state == ST_INIT);
        core_hold_o  = core_rst_o || (cur_q.state == ST_STOPPED);
        fetch_addr_o = cur_q.fetch;
        state_o      = cur_q.state;
        wake_err_o   = cur_q.err;
    end

endmodule

// File: rtl/boot_runctl_chk.sv
module boot_runctl_chk
    import boot_runctl_pkg::*;
#(
    parameter int unsigned ID_W      = 2,
    parameter int unsigned ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] ROM_ENTRY = 32'hFFF0_0100
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [ID_W-1:0]    self_id_i,
    input logic               elect_valid_i,
    input logic               wake_valid_i,
    input logic [ID_W-1:0]    wake_target_i,
    input logic [ADDR_W-1:0]  wake_addr_i,
    input logic               core_rst_o,
    input logic               core_hold_o,
    input logic [ADDR_W-1:0]  fetch_addr_o,
    input logic [STATE_W-1:0] state_o,
    input logic               wake_err_o
);

    assert_init_in_reset_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_INIT) |-> (core_rst_o && core_hold_o));

    assert_boot_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_RUN_BOOT) |-> (fetch_addr_o == ROM_ENTRY && !core_rst_o && !core_hold_o));

    assert_boot_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_RUN_BOOT) |=> (state_o == ST_ELECT_WAIT));

    assert_elect_wait_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_ELECT_WAIT && !elect_valid_i) |=> (state_o == ST_ELECT_WAIT));

    assert_stopped_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_STOPPED) |-> (core_hold_o && !core_rst_o && fetch_addr_o == '0));

    assert_wake_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_STOPPED && wake_valid_i && wake_target_i == self_id_i)
        |=> (state_o == ST_RUN_SECONDARY && fetch_addr_o == $past(wake_addr_i)));

    assert_foreign_wake_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_STOPPED && wake_valid_i && wake_target_i != self_id_i)
        |=> (state_o == ST_STOPPED && $stable(wake_err_o)));

    assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_err_o |=> wake_err_o);

    assert_master_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == ST_MASTER_RUN) |=> (state_o == ST_MASTER_RUN && fetch_addr_o == ROM_ENTRY));

endmodule

bind boot_runctl boot_runctl_chk #(
    .ID_W      (ID_W),
    .ADDR_W    (ADDR_W),
    .ROM_ENTRY (ROM_ENTRY)
) i_boot_runctl_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .self_id_i     (self_id_i),
    .elect_valid_i (elect_valid_i),
    .wake_valid_i  (wake_valid_i),
    .wake_target_i (wake_target_i),
    .wake_addr_i   (wake_addr_i),
    .core_rst_o    (core_rst_o),
    .core_hold_o   (core_hold_o),
    .fetch_addr_o  (fetch_addr_o),
    .state_o       (state_o),
    .wake_err_o    (wake_err_o)
);

// File: tb/test_boot_runctl.sv
module test_boot_runctl;

    localparam int unsigned ID_W   = 2;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned CNT_W  = 8;
    localparam logic [ADDR_W-1:0] ROM = 32'hFFF0_0100;
    localparam logic [ID_W-1:0]   MY_ID = 2'd2;

    localparam logic [2:0] S_RST = 3'd0, S_INIT = 3'd1, S_BOOT = 3'd2, S_ELECT = 3'd3,
                           S_MAST = 3'd4, S_STOP = 3'd5, S_SEC = 3'd6;

    typedef struct packed {
        logic [7:0]  len;
        logic        master;
        logic [1:0]  tgt;
        logic [31:0] addr;
        logic [2:0]  exp_state;
        logic [31:0] exp_fetch;
        logic        exp_err;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{8'd4,  1'b1, 2'd2, 32'h0000_1000, 3'd4, 32'hFFF0_0100, 1'b1},
        '{8'd1,  1'b0, 2'd2, 32'h2000_0040, 3'd6, 32'h2000_0040, 1'b0},
        '{8'd0,  1'b0, 2'd1, 32'h0000_3000, 3'd5, 32'h0000_0000, 1'b0},
        '{8'd7,  1'b1, 2'd3, 32'h0000_4000, 3'd4, 32'hFFF0_0100, 1'b0},
        '{8'd2,  1'b0, 2'd2, 32'h0000_0000, 3'd6, 32'h0000_0000, 1'b0},
        '{8'd12, 1'b0, 2'd0, 32'hDEAD_BEE0, 3'd5, 32'h0000_0000, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CNT_W-1:0]  init_len = '0;
    logic              elect_valid = 1'b0;
    logic              elect_master = 1'b0;
    logic              wake_valid = 1'b0;
    logic [ID_W-1:0]   wake_target = '0;
    logic [ADDR_W-1:0] wake_addr = '0;
    logic              core_rst, core_hold, wake_err;
    logic [ADDR_W-1:0] fetch_addr;
    logic [2:0]        state;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    boot_runctl #(
        .ID_W (ID_W), .ADDR_W (ADDR_W), .CNT_W (CNT_W), .ROM_ENTRY (ROM)
    ) i_boot_runctl (
        .clk_i (clk), .rst_ni (rst_n), .self_id_i (MY_ID), .init_len_i (init_len),
        .elect_valid_i (elect_valid), .elect_master_i (elect_master),
        .wake_valid_i (wake_valid), .wake_target_i (wake_target), .wake_addr_i (wake_addr),
        .core_rst_o (core_rst), .core_hold_o (core_hold), .fetch_addr_o (fetch_addr),
        .state_o (state), .wake_err_o (wake_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reset, check the reset state (R1), release, and walk to the election wait.
    task automatic boot_to_elect(input logic [7:0] len);
        int cycles;
        int expect_cycles;
        rst_n = 1'b0; elect_valid = 1'b0; wake_valid = 1'b0; init_len = len;
        repeat (2) @(negedge clk);
        chk("R1 state", {29'd0, state}, {29'd0, S_RST});
        chk("R1 rst/hold", {30'd0, core_rst, core_hold}, 32'd3);
        chk("R1 fetch", fetch_addr, 32'd0);
        chk("R1 err", {31'd0, wake_err}, 32'd0);
        rst_n = 1'b1;
        expect_cycles = ((len == 0) ? 1 : int'(len)) + 1;
        cycles = 0;
        while (cycles < 300) begin
            @(negedge clk);
            cycles++;
            if (state == S_BOOT) break;
            if (state != S_INIT)
                chk("R2 in init", {29'd0, state}, {29'd0, S_INIT});
            else if (!(core_rst && core_hold))
                chk("R2 held in init", {30'd0, core_rst, core_hold}, 32'd3);
        end
        chk("R2 init length", cycles, expect_cycles);
        chk("R3 boot fetch", fetch_addr, ROM);
        chk("R3 released", {30'd0, core_rst, core_hold}, 32'd0);
        @(negedge clk);
        chk("R3 to elect wait", {29'd0, state}, {29'd0, S_ELECT});
    endtask

    task automatic elect(input logic master);
        elect_valid = 1'b1; elect_master = master;
        @(negedge clk);
        elect_valid = 1'b0;
        chk("R4 election result", {29'd0, state}, {29'd0, master ? S_MAST : S_STOP});
        if (!master) begin
            chk("R5 stopped hold", {30'd0, core_rst, core_hold}, 32'd1);
            chk("R5 stopped fetch", fetch_addr, 32'd0);
        end
    endtask

    task automatic wake(input logic [1:0] tgt, input logic [31:0] addr);
        wake_valid = 1'b1; wake_target = tgt; wake_addr = addr;
        @(negedge clk);
        wake_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // Table-driven scenarios: boot, elect, then one wake request.
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            boot_to_elect(VECS[i].len);
            elect(VECS[i].master);
            wake(VECS[i].tgt, VECS[i].addr);
            if (VECS[i].exp_state == S_SEC) tag = "R6";
            else if (VECS[i].exp_err) tag = "R8";
            else if (VECS[i].exp_state == S_MAST) tag = "R9";
            else tag = "R7";
            chk({tag, " state"}, {29'd0, state}, {29'd0, VECS[i].exp_state});
            chk({tag, " fetch"}, fetch_addr, VECS[i].exp_fetch);
            chk({tag, " err"}, {31'd0, wake_err}, {31'd0, VECS[i].exp_err});
            if (VECS[i].exp_state == S_SEC)
                chk("R6 hold released", {31'd0, core_hold}, 32'd0);
        end

        // R4: election pulses outside the wait state are ignored; the wait holds.
        rst_n = 1'b0; init_len = 8'd5;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        elect_valid = 1'b1; elect_master = 1'b0;
        repeat (3) @(negedge clk);
        elect_valid = 1'b0;
        chk("R4 elect ignored in init", {29'd0, state}, {29'd0, S_INIT});
        while (state != S_ELECT) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R4 wait holds", {29'd0, state}, {29'd0, S_ELECT});
        elect(1'b1);
        repeat (4) @(negedge clk);
        chk("R9 master persists", {29'd0, state}, {29'd0, S_MAST});
        chk("R9 master fetch", fetch_addr, ROM);

        // R8: matching wake during init is ignored but flags an error that persists.
        rst_n = 1'b0; init_len = 8'd6;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        wake(MY_ID, 32'h0000_0055);
        chk("R8 init state kept", {29'd0, state}, {29'd0, S_INIT});
        chk("R8 init fetch kept", fetch_addr, 32'd0);
        chk("R8 err set", {31'd0, wake_err}, 32'd1);
        while (state != S_BOOT) @(negedge clk);
        chk("R8 boot fetch unaffected", fetch_addr, ROM);
        chk("R8 err sticky", {31'd0, wake_err}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 err cleared", {31'd0, wake_err}, 32'd0);

        // R7 then R6 then R8: foreign wakes while parked, accepted wake, second wake.
        boot_to_elect(8'd3);
        elect(1'b0);
        wake(2'd0, 32'h0000_0AA0);
        wake(2'd3, 32'h0000_0BB0);
        chk("R7 still stopped", {29'd0, state}, {29'd0, S_STOP});
        chk("R7 no err", {31'd0, wake_err}, 32'd0);
        chk("R7 fetch cleared", fetch_addr, 32'd0);
        wake(MY_ID, 32'h0001_2340);
        chk("R6 secondary", {29'd0, state}, {29'd0, S_SEC});
        chk("R6 entry", fetch_addr, 32'h0001_2340);
        wake(MY_ID, 32'h0005_6780);
        chk("R8 second wake state", {29'd0, state}, {29'd0, S_SEC});
        chk("R8 second wake fetch", fetch_addr, 32'h0001_2340);
        chk("R8 second wake err", {31'd0, wake_err}, 32'd1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule